// File: doc/BRIEF.md
# Two-Level Page Table Walker

The block turns a 32-bit virtual address into a physical address. It reads two translation entries from memory, one after the other. A page-aligned base input gives the physical location of a 1024-entry directory. Bits 31:22 of the virtual address select a directory entry. That entry points to a 1024-entry table, and bits 21:12 select the table entry. The table entry supplies the frame base, and the low 12 bits of the virtual address are appended to it as the byte offset.

While it walks, the block checks the request against three flag bits in each entry: present (bit 0), writable (bit 1) and user (bit 2). When an entry is absent, or when the access is not allowed, the walk ends with a fault. A fault carries a three-bit error code, and the faulting virtual address is stored in a register that holds its value until the next fault. The walker handles one request at a time. It issues at most one memory read at a time, holds each read until the memory acknowledges it, and gives a one-cycle response.

Top module: `pgwalk_top`

## Requirements
- R1: After a synchronous active-low reset, the block is ready to accept a request, no memory read and no response is active, and the fault address register reads zero.
- R2: The first read of a walk is at {base[31:12], va[31:22], 2'b00}. The low 12 bits of the base input have no effect on this address.
- R3: When the directory entry is present, the second read is at {dir_entry[31:12], va[21:12], 2'b00}, and it is issued only after the first read is acknowledged.
- R4: A walk with no fault responds with fault flag 0, error code 000, and physical address {table_entry[31:12], va[11:0]}.
- R5: A directory entry with bit 0 clear ends the walk with a fault after exactly one read. Error code bit 0 is 0.
- R6: A table entry with bit 0 clear gives a fault with error code bit 0 equal to 0. Its writable and user bits are not evaluated.
- R7: A write faults with error code bit 0 equal to 1 when the AND of the writable bits (bit 1) of both entries is 0. For a read, the writable bits have no effect.
- R8: A user-privilege access faults with error code bit 0 equal to 1 when the AND of the user bits (bit 2) of both entries is 0. For a supervisor access, the user bits have no effect.
- R9: In every fault, error code bit 1 equals the write flag of the request and bit 2 equals its user flag.
- R10: Every fault loads the faulting virtual address into the fault address register. A walk that succeeds leaves the register unchanged.
- R11: The response valid signal is high for exactly one cycle per walk. A request is taken only while the ready output is high, and ready is low from acceptance through the response cycle.
- R12: A read request stays asserted, with a stable address, until the memory acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_base | input | 32 | Physical base of the directory; bits 11:0 ignored |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; the request is taken at this edge |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| mem_req | output | 1 | Entry read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_paddr | output | 32 | Translated physical address (valid when no fault) |
| rsp_errcode | output | 3 | Fault error code: {user, write, protection} |
| fault_vaddr | output | 32 | Virtual address of the most recent fault |

## Verification
The overlap of interest is a new request arriving in the same cycle that the previous walk responds. The bench keeps request valid high through the response cycle of a faulting walk, with a second address already on the port. It checks that ready is low in that cycle and that the second walk reads its own directory entry afterwards. It also checks that the fault address register still holds the first address after the second walk succeeds. Random walks with random acknowledge delays are compared against a reference computed in the bench.

// File: rtl/pgwalk_pkg.sv
// Shared constants and the walker state type.
// Assumes entries are four bytes wide, so entry addresses are word aligned.
package pgwalk_pkg;
    localparam int ENT_LOG = 2;   // log2 of entry size in bytes
    localparam int BIT_P   = 0;   // present flag position
    localparam int BIT_W   = 1;   // writable flag position
    localparam int BIT_U   = 2;   // user flag position

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_TBL,
        ST_DONE,
        ST_FAULT
    } walk_st_t;
endpackage

// File: rtl/pgwalk_seq.sv
// Walk sequencer: captures a request when idle, then steps through the
// directory read, the table read and a response state.
// Assumes mem_ack is only asserted while a read is requested.
module pgwalk_seq
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              entry_fault,
    output walk_st_t          st,
    output logic [ADDR_W-1:0] vaddr_q,
    output logic              write_q,
    output logic              user_q,
    output logic [ADDR_W-1:0] dir_ent_q
);
    // State register and request / directory entry capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            vaddr_q   <= '0;
            write_q   <= 1'b0;
            user_q    <= 1'b0;
            dir_ent_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    write_q <= req_write;
                    user_q  <= req_user;
                    st      <= ST_RD_DIR;
                end
                ST_RD_DIR: if (mem_ack) begin
                    dir_ent_q <= mem_rdata;
                    st        <= entry_fault ? ST_FAULT : ST_RD_TBL;
                end
                ST_RD_TBL: if (mem_ack) begin
                    st <= entry_fault ? ST_FAULT : ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // An absent directory entry must go straight to the fault state.
    p_absent_dir_skips_table_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD_DIR && mem_ack && !mem_rdata[BIT_P]) |=> (st == ST_FAULT));

    // The captured request must not change while a walk is in flight.
    p_request_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> ($stable(vaddr_q) && $stable(write_q) && $stable(user_q)));
endmodule

// File: rtl/pgwalk_addr.sv
// Address former: builds the entry read address for the current step and
// the final physical address from a table entry.
// Assumes the offset width equals index width plus entry size log2.
module pgwalk_addr
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic              at_table,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] dir_ent,
    input  logic [ADDR_W-1:0] tbl_ent,
    output logic [ADDR_W-1:0] entry_addr,
    output logic [ADDR_W-1:0] phys_addr
);
    localparam int OFF_W = IDX_W + ENT_LOG;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    // Split the virtual address into its two index fields.
    always_comb begin
        dir_idx = vaddr[ADDR_W-1 -: IDX_W];
        tbl_idx = vaddr[OFF_W+IDX_W-1 -: IDX_W];
    end

    // Pick the base and index for the step in progress.
    always_comb begin
        if (at_table)
            entry_addr = {dir_ent[ADDR_W-1:OFF_W], tbl_idx, {ENT_LOG{1'b0}}};
        else
            entry_addr = {dir_base[ADDR_W-1:OFF_W], dir_idx, {ENT_LOG{1'b0}}};
    end

    // Join the frame base with the byte offset.
    always_comb begin
        phys_addr = {tbl_ent[ADDR_W-1:OFF_W], vaddr[OFF_W-1:0]};
    end
endmodule

// File: rtl/pgwalk_perm.sv
// Permission checker: decides whether the entry just read ends the walk
// with a fault and forms the error code {user, write, protection}.
// Assumes dir_ent holds the directory entry when at_table is high.
module pgwalk_perm
    import pgwalk_pkg::*;
(
    input  logic       at_table,
    input  logic [2:0] entry_flags,
    input  logic [2:0] dir_flags,
    input  logic       is_write,
    input  logic       is_user,
    output logic       fault,
    output logic [2:0] errcode
);
    logic present;
    logic wr_ok;
    logic usr_ok;
    logic prot;

    // Combine the flags of both levels and test them against the request.
    always_comb begin
        present = entry_flags[BIT_P];
        wr_ok   = dir_flags[BIT_W] & entry_flags[BIT_W];
        usr_ok  = dir_flags[BIT_U] & entry_flags[BIT_U];
        prot    = at_table && present && ((is_write && !wr_ok) || (is_user && !usr_ok));
        fault   = !present || prot;
        errcode = {is_user, is_write, prot};
    end
endmodule

// File: rtl/pgwalk_top.sv
// Two-level page table walker top: joins the sequencer, the address former
// and the permission checker, and registers the response and fault address.
// Assumes one outstanding memory read and a base that stays stable per walk.
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [2:0]        rsp_errcode,
    output logic [ADDR_W-1:0] fault_vaddr
);
    localparam int OFF_W = IDX_W + ENT_LOG;

    walk_st_t          st;
    logic [ADDR_W-1:0] vaddr_q;
    logic              write_q;
    logic              user_q;
    logic [ADDR_W-1:0] dir_ent_q;
    logic              at_table;
    logic              entry_fault;
    logic [2:0]        entry_err;
    logic [ADDR_W-1:0] phys_addr;
    logic [ADDR_W-1:0] paddr_q;
    logic [2:0]        err_q;
    logic [ADDR_W-1:0] fva_q;
    logic              unused_bits;

    assign at_table    = (st == ST_RD_TBL);
    assign unused_bits = ^{dir_base[OFF_W-1:0], dir_ent_q[OFF_W-1:3], mem_rdata[OFF_W-1:3]};

    pgwalk_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .entry_fault(entry_fault),
        .st(st), .vaddr_q(vaddr_q), .write_q(write_q),
        .user_q(user_q), .dir_ent_q(dir_ent_q)
    );

    pgwalk_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) addr_i (
        .at_table(at_table), .dir_base(dir_base), .vaddr(vaddr_q),
        .dir_ent(dir_ent_q), .tbl_ent(mem_rdata),
        .entry_addr(mem_addr), .phys_addr(phys_addr)
    );

    pgwalk_perm perm_i (
        .at_table(at_table), .entry_flags(mem_rdata[2:0]),
        .dir_flags(dir_ent_q[2:0]), .is_write(write_q), .is_user(user_q),
        .fault(entry_fault), .errcode(entry_err)
    );

    // Decode handshake and response strobes from the walk state.
    always_comb begin
        req_ready = (st == ST_IDLE);
        mem_req   = (st == ST_RD_DIR) || (st == ST_RD_TBL);
        rsp_valid = (st == ST_DONE) || (st == ST_FAULT);
        rsp_fault = (st == ST_FAULT);
    end

    // Register the result of the final read and the faulting address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            err_q   <= '0;
            fva_q   <= '0;
        end else if (mem_req && mem_ack) begin
            if (entry_fault) begin
                err_q <= entry_err;
                fva_q <= vaddr_q;
            end else if (at_table) begin
                err_q   <= '0;
                paddr_q <= phys_addr;
            end
        end
    end

    assign rsp_paddr   = paddr_q;
    assign rsp_errcode = err_q;
    assign fault_vaddr = fva_q;

    // A response lasts a single cycle.
    p_rsp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // No read and no response while ready for a new request.
    p_ready_only_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid));

    // An unacknowledged read keeps its request and address.
    p_read_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // Fault code upper bits mirror the captured request.
    p_err_mirrors_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_errcode[1] == write_q && rsp_errcode[2] == user_q));

    // A successful walk does not disturb the fault address register.
    p_fva_kept_on_success_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> $stable(fault_vaddr));
endmodule

// File: tb/pgwalk_top_tb.sv
// Self-checking bench: directed corner cases plus seeded random walks,
// against a memory model with random acknowledge delay.
module pgwalk_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dir_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_errcode;
    logic [31:0] fault_vaddr;

    int n_chk = 0;
    int n_fail = 0;
    int nrd = 0;
    int walk_base = 0;
    int delay_cnt = 0;
    logic [31:0] pde_val = '0;
    logic [31:0] pte_val = '0;
    logic [31:0] rd_log [0:3];
    logic [31:0] exp_fva = '0;

    always #4 clk = ~clk;

    pgwalk_top dut_i (
        .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_errcode(rsp_errcode), .fault_vaddr(fault_vaddr)
    );

    // Memory model: answers each read after 0..3 idle cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            delay_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack   <= 1'b0;
            delay_cnt <= int'($urandom % 4);
        end else if (mem_req) begin
            if (delay_cnt == 0) begin
                mem_ack   <= 1'b1;
                mem_rdata <= (nrd - walk_base == 0) ? pde_val : pte_val;
                if (nrd - walk_base < 4) rd_log[nrd - walk_base] <= mem_addr;
                nrd       <= nrd + 1;
            end else begin
                delay_cnt <= delay_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Reference outcome of one walk, built from the requirements.
    task automatic ref_walk(input logic [31:0] va, input bit w, input bit u,
                            input logic [31:0] base, input logic [31:0] pde, input logic [31:0] pte,
                            output bit f, output logic [2:0] ec, output logic [31:0] pa,
                            output logic [31:0] a0, output logic [31:0] a1, output int nreads,
                            output string tag);
        bit prot;
        a0 = {base[31:12], va[31:22], 2'b00};
        a1 = {pde[31:12], va[21:12], 2'b00};
        pa = {pte[31:12], va[11:0]};
        prot = 1'b0;
        if (!pde[0]) begin
            f = 1'b1; nreads = 1; tag = "R5";
        end else begin
            nreads = 2;
            if (!pte[0]) begin
                f = 1'b1; tag = "R6";
            end else begin
                prot = (w && !(pde[1] && pte[1])) || (u && !(pde[2] && pte[2]));
                f = prot;
                tag = prot ? (w && !(pde[1] && pte[1]) ? "R7" : "R8") : "R4";
            end
        end
        ec = f ? {u, w, prot} : 3'b000;
    endtask

    task automatic wait_rsp();
        int k = 0;
        while (!rsp_valid && k < 64) begin
            @(negedge clk);
            k++;
        end
    endtask

    // Compare one completed response against the reference.
    task automatic check_rsp(input logic [31:0] va, input bit f, input logic [2:0] ec,
                             input logic [31:0] pa, input logic [31:0] a0, input logic [31:0] a1,
                             input int nreads, input string tag);
        chk(rsp_valid == 1'b1, {tag, " response seen"}, 32'(rsp_valid), 32'd1);
        chk(rsp_fault == f, {tag, " fault flag"}, 32'(rsp_fault), 32'(f));
        chk(rsp_errcode == ec, {tag, "/R9 error code"}, 32'(rsp_errcode), 32'(ec));
        if (!f) chk(rsp_paddr == pa, "R4 physical address", rsp_paddr, pa);
        chk(nrd - walk_base == nreads, {tag, "/R5 read count"}, 32'(nrd - walk_base), 32'(nreads));
        chk(rd_log[0] == a0, "R2 directory entry address", rd_log[0], a0);
        if (nreads == 2) chk(rd_log[1] == a1, "R3 table entry address", rd_log[1], a1);
        if (f) exp_fva = va;
        chk(fault_vaddr == exp_fva, "R10 fault address register", fault_vaddr, exp_fva);
        chk(req_ready == 1'b0, "R11 not ready during response", 32'(req_ready), 32'd0);
    endtask

    task automatic run_walk(input logic [31:0] va, input bit w, input bit u,
                            input logic [31:0] base, input logic [31:0] pde, input logic [31:0] pte);
        bit f; logic [2:0] ec; logic [31:0] pa, a0, a1; int nr; string tag;
        ref_walk(va, w, u, base, pde, pte, f, ec, pa, a0, a1, nr, tag);
        while (!req_ready) @(negedge clk);
        dir_base = base; pde_val = pde; pte_val = pte; walk_base = nrd;
        rd_log[0] = 'x; rd_log[1] = 'x;
        req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11 busy after accept", 32'(req_ready), 32'd0);
        wait_rsp();
        check_rsp(va, f, ec, pa, a0, a1, nr, tag);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11 single-cycle response", 32'(rsp_valid), 32'd0);
    endtask

    // Watchdog: a hung run still reaches the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary_and_end();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(mem_req == 1'b0, "R1 no read after reset", 32'(mem_req), 32'd0);
        chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
        chk(fault_vaddr == 32'd0, "R1 fault address cleared", fault_vaddr, 32'd0);

        // R4: plain success; R2: base low bits ignored
        run_walk(32'h0000_8123, 1'b0, 1'b0, 32'h0010_0000, 32'h0020_0007, 32'h000B_8007);
        run_walk(32'hFFC0_1ABC, 1'b1, 1'b1, 32'h0030_0FFF, 32'h1234_5007, 32'hABCD_E007);
        // R5: absent directory entry
        run_walk(32'h4040_4040, 1'b1, 1'b0, 32'h0010_0000, 32'h0020_0006, 32'h000B_8007);
        // R6: absent table entry, other flags would deny too
        run_walk(32'h0123_4567, 1'b0, 1'b1, 32'h0010_0000, 32'h0020_0007, 32'h0000_0000);
        // R7: read-only at table level, then at directory level
        run_walk(32'h0800_1000, 1'b1, 1'b0, 32'h0010_0000, 32'h0020_0007, 32'h0033_3005);
        run_walk(32'h0800_2000, 1'b1, 1'b1, 32'h0010_0000, 32'h0020_0005, 32'h0033_3007);
        // R7: read of read-only page is fine
        run_walk(32'h0800_3004, 1'b0, 1'b1, 32'h0010_0000, 32'h0020_0005, 32'h0044_4005);
        // R8: user on supervisor page faults; supervisor on it succeeds
        run_walk(32'h0900_0010, 1'b0, 1'b1, 32'h0010_0000, 32'h0020_0003, 32'h0055_5007);
        run_walk(32'h0900_0020, 1'b1, 1'b0, 32'h0010_0000, 32'h0020_0003, 32'h0055_5003);

        // R11/R10 overlap: fault walk A with request held through its response
        begin
            bit f; logic [2:0] ec; logic [31:0] pa, a0, a1; int nr; string tag;
            while (!req_ready) @(negedge clk);
            dir_base = 32'h0070_0000; pde_val = 32'h0080_0007; pte_val = 32'h0090_0001;
            walk_base = nrd;
            req_vaddr = 32'hA5A5_5A5A; req_write = 1'b1; req_user = 1'b0; req_valid = 1'b1;
            @(negedge clk);
            wait_rsp();
            ref_walk(32'hA5A5_5A5A, 1'b1, 1'b0, 32'h0070_0000, 32'h0080_0007, 32'h0090_0001,
                     f, ec, pa, a0, a1, nr, tag);
            check_rsp(32'hA5A5_5A5A, f, ec, pa, a0, a1, nr, tag);
            req_vaddr = 32'h1357_9BDF; req_write = 1'b0; req_user = 1'b0;
            pde_val = 32'h00C0_0007; pte_val = 32'h00D0_0007; walk_base = nrd;
            @(negedge clk);
            chk(req_ready == 1'b1, "R11 ready after response", 32'(req_ready), 32'd1);
            @(negedge clk);
            req_valid = 1'b0;
            wait_rsp();
            ref_walk(32'h1357_9BDF, 1'b0, 1'b0, 32'h0070_0000, 32'h00C0_0007, 32'h00D0_0007,
                     f, ec, pa, a0, a1, nr, tag);
            check_rsp(32'h1357_9BDF, f, ec, pa, a0, a1, nr, tag);
            chk(fault_vaddr == 32'hA5A5_5A5A, "R10 held across later success",
                fault_vaddr, 32'hA5A5_5A5A);
            @(negedge clk);
        end

        // Random walks, mostly present entries
        for (int i = 0; i < 300; i++) begin
            logic [31:0] pde, pte;
            pde = $urandom;
            pte = $urandom;
            pde[0] = ($urandom % 8) != 0;
            pte[0] = ($urandom % 8) != 0;
            run_walk($urandom, 1'($urandom), 1'($urandom), $urandom, pde, pte);
        end

        summary_and_end();
    end
endmodule